// File: doc/BRIEF.md
# Two-Wire Latching Shift Transmitter

This block turns a 12-bit parallel word into the clock and data waveforms that load a shift receiver which has no separate latch pin. The receiver takes each data bit on a rising clock edge. It copies its shift contents to its outputs only on a falling edge where the data line is high. The receiver cannot see where a word starts or ends, so the transmitter counts the bits itself. It keeps data low across the first eleven falling edges and raises it for the twelfth.

Every bit is sent in four equal phases. In the first phase the clock is low and data carries the bit value. In the second the clock is high and data still carries the bit. In the third the clock is still high and data carries the latch flag. In the fourth the clock is low and data keeps the flag. Each phase lasts a programmable number of system cycles. That count and the word are both captured when a start request is accepted. The host pulses `start` while the block is idle, watches `busy`, and receives a one-cycle `done` pulse when the word has been latched.

Top module: `latch_shift_tx`

## Requirements
- R1: A transfer produces exactly 12 rising edges on `sclk`. `sdata` at each rising edge carries one word bit, with bit 11 first and bit 0 last, so a receiver that shifts left on each rise holds the original word.
- R2: On each of the first 11 falling edges of `sclk` in a transfer, `sdata` is low.
- R3: On the 12th falling edge of `sclk`, `sdata` is high. A receiver therefore latches exactly once per transfer.
- R4: Whenever `busy` is low, `sclk` and `sdata` are both low.
- R5: Each phase lasts D system cycles, where D is the captured divider value and a value of 0 counts as 1. `busy` is therefore high for exactly 48×D consecutive cycles.
- R6: `sdata` never changes in the same cycle that `sclk` changes.
- R7: `busy` rises in the cycle after a start is accepted. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R8: A start request that arrives while `busy` is high is ignored. The current word finishes unchanged and no extra transfer follows.
- R9: Changes to `word_in` or `div_in` after acceptance have no effect on the running transfer.
- R10: A start request in the cycle where `done` is high is accepted, and the next transfer begins with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 12 | Word to send, captured at acceptance |
| start | input | 1 | Start request, accepted while not busy |
| div_in | input | 8 | Phase length in system cycles, captured at acceptance; 0 acts as 1 |
| sclk | output | 1 | Serial clock to the receiver |
| sdata | output | 1 | Serial data and latch flag to the receiver |
| busy | output | 1 | High while a word is being sent |
| done | output | 1 | One-cycle pulse after the final phase |

## Verification
The end-of-word pulse and the acceptance of the next word can land on the same cycle. The bench provokes this by raising `start` with a new word and divider exactly in the sampled cycle where `done` is high. It then judges the result three ways. `busy` must be high in the very next cycle. The second word must be latched by the bench's receiver model with its own divider timing. The first word's latch must not be disturbed. The other overlap tested is a start arriving mid-word together with changes to `word_in` and `div_in`; this must leave the running word's content and length untouched.

// File: rtl/lstx_pkg.sv
// Package: shared phase type for the two-wire latching shift transmitter.
// Assumes: each bit is sent as four equal phases in the listed order.
package lstx_pkg;
    typedef enum logic [1:0] {
        PH_SETUP = 2'd0,   // clock low, data = bit value
        PH_RISE  = 2'd1,   // clock high, data = bit value
        PH_FLAG  = 2'd2,   // clock high, data = latch flag
        PH_FALL  = 2'd3    // clock low, data = latch flag
    } lstx_phase_t;
endpackage

// File: rtl/lstx_divider.sv
// Module: phase timer. It counts system cycles and pulses `tick` on the last
// cycle of each phase.
// Assumes: `load` arrives only while `run` is low; a zero divider acts as one.
module lstx_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_val,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;

    // Purpose: flag the last cycle of the current phase.
    always_comb begin
        tick = run && (cnt_q == lim_q - DIV_W'(1));
    end

    // Purpose: capture the phase length at acceptance and run the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= DIV_W'(1);
            cnt_q <= '0;
        end else if (load) begin
            lim_q <= (div_val == '0) ? DIV_W'(1) : div_val;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/lstx_shifter.sv
// Module: word holder. It loads the parallel word and shifts it left once per
// completed bit.
// Assumes: `load` and `shift` are never high in the same cycle.
module lstx_shifter #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    output logic              bit_out
);
    logic [WORD_W-1:0] sreg_q;

    // Purpose: present the bit that is currently being sent.
    always_comb begin
        bit_out = sreg_q[WORD_W-1];
    end

    // Purpose: load the word at acceptance, then move the next bit to the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= word;
        end else if (shift) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/lstx_sequencer.sv
// Module: bit and phase sequencer. It accepts start requests, steps through
// four phases per bit, counts the bits, and emits busy and done.
// Assumes: `tick` comes from a timer that is loaded at the same acceptance.
module lstx_sequencer #(
    parameter int WORD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                tick,
    output logic                busy,
    output logic                done,
    output lstx_pkg::lstx_phase_t phase,
    output logic                last_bit,
    output logic                load,
    output logic                shift
);
    import lstx_pkg::*;

    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] idx_q;

    // Purpose: decode acceptance, last-bit state and shift strobe.
    always_comb begin
        load     = start && !busy;
        last_bit = (idx_q == LAST_IDX);
        shift    = busy && tick && (phase == PH_FALL) && !last_bit;
    end

    // Purpose: advance phases and bits, and end the word with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            phase <= PH_SETUP;
            idx_q <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy  <= 1'b1;
                phase <= PH_SETUP;
                idx_q <= '0;
            end else if (busy && tick) begin
                case (phase)
                    PH_SETUP: phase <= PH_RISE;
                    PH_RISE:  phase <= PH_FLAG;
                    PH_FLAG:  phase <= PH_FALL;
                    default: begin
                        phase <= PH_SETUP;
                        if (last_bit) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/latch_shift_tx.sv
// Module: two-wire latching shift transmitter (top). It serializes one word
// per start request and marks the final falling clock edge with data high.
// Assumes: the receiver samples data on the rising clock edge and latches on
// a falling edge with data high. Outputs are decoded from registered state.
module latch_shift_tx #(
    parameter int WORD_W = 12,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_in,
    output logic              sclk,
    output logic              sdata,
    output logic              busy,
    output logic              done
);
    import lstx_pkg::*;

    logic        tick;
    logic        load;
    logic        shift;
    logic        last_bit;
    logic        cur_bit;
    lstx_phase_t phase;

    lstx_sequencer #(.WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .busy     (busy),
        .done     (done),
        .phase    (phase),
        .last_bit (last_bit),
        .load     (load),
        .shift    (shift)
    );

    lstx_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .div_val (div_in),
        .run     (busy),
        .tick    (tick)
    );

    lstx_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .word    (word_in),
        .shift   (shift),
        .bit_out (cur_bit)
    );

    // Purpose: map the phase onto the clock level and data meaning.
    always_comb begin
        sclk  = busy && ((phase == PH_RISE) || (phase == PH_FLAG));
        sdata = busy && (((phase == PH_SETUP) || (phase == PH_RISE)) ? cur_bit : last_bit);
    end
endmodule

// File: rtl/lstx_checker.sv
// Module: property checker for the transmitter, bound to the top module.
// Assumes: reset is asserted from time zero.
module lstx_checker #(
    parameter int WORD_W = 12
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic sdata,
    input logic busy,
    input logic done
);
    localparam int FC_W = $clog2(WORD_W + 1);
    localparam logic [FC_W-1:0] LAST_FALL = FC_W'(WORD_W - 1);

    logic            sclk_d;
    logic [FC_W-1:0] falls_q;

    // Purpose: count the falling clock edges already seen in this word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            falls_q <= '0;
        end else begin
            sclk_d <= sclk;
            if (done) begin
                falls_q <= '0;
            end else if (sclk_d && !sclk) begin
                falls_q <= falls_q + FC_W'(1);
            end
        end
    end

    p_flag_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_d && !sclk && falls_q != LAST_FALL) |-> !sdata);

    p_flag_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_d && !sclk && falls_q == LAST_FALL) |-> sdata);

    p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdata));

    p_edge_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sclk) |-> $stable(sdata));

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));
endmodule

bind latch_shift_tx lstx_checker #(.WORD_W(WORD_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .sclk  (sclk),
    .sdata (sdata),
    .busy  (busy),
    .done  (done)
);

// File: tb/tb_latch_shift_tx.sv
`timescale 1ns/1ps
module tb_latch_shift_tx;
    localparam int WORD_W = 12;
    localparam int DIV_W  = 8;
    localparam int NVEC   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] word_in = '0;
    logic              start = 1'b0;
    logic [DIV_W-1:0]  div_in = '0;
    logic              sclk, sdata, busy, done;

    int total = 0;
    int bad = 0;

    // receiver model state
    logic              sclk_prev = 1'b0;
    logic [WORD_W-1:0] rx_shift = '0;
    logic [WORD_W-1:0] rx_latched = '0;
    int                rx_rises = 0;
    int                rx_falls = 0;
    int                rx_latches = 0;
    int                rx_flag_err = 0;

    // vectors: {div, word}
    localparam logic [DIV_W+WORD_W-1:0] VEC [NVEC] = '{
        {8'd1, 12'hA5C},
        {8'd0, 12'h000},
        {8'd2, 12'hFFF},
        {8'd3, 12'h801},
        {8'd1, 12'h001},
        {8'd4, 12'h7FE}
    };

    latch_shift_tx #(.WORD_W(WORD_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .start(start),
        .div_in(div_in), .sclk(sclk), .sdata(sdata), .busy(busy), .done(done)
    );

    always #2 clk = ~clk;

    // receiver: shift on rise, latch on a fall with data high
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sclk_prev && sclk) begin
                rx_shift = {rx_shift[WORD_W-2:0], sdata};
                rx_rises = rx_rises + 1;
            end
            if (sclk_prev && !sclk) begin
                rx_falls = rx_falls + 1;
                if (sdata) begin
                    rx_latched = rx_shift;
                    rx_latches = rx_latches + 1;
                    if (rx_falls != WORD_W) rx_flag_err = rx_flag_err + 1;
                end else if (rx_falls == WORD_W) begin
                    rx_flag_err = rx_flag_err + 1;
                end
                if (rx_falls == WORD_W) rx_falls = 0;
            end
        end
        sclk_prev = sclk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // starts a word at the current negedge and counts busy cycles until the done cycle
    task automatic send(input logic [WORD_W-1:0] w, input logic [DIV_W-1:0] d,
                        output int cyc);
        word_in = w; div_in = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc, lat0, err0, rise0, dexp;
        repeat (3) @(negedge clk);
        // R4 reset state
        check("R4 reset sclk", 32'(sclk), 0);
        check("R4 reset sdata", 32'(sdata), 0);
        check("R7 reset busy/done", 32'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            lat0 = rx_latches; err0 = rx_flag_err; rise0 = rx_rises;
            dexp = (VEC[i][DIV_W+WORD_W-1:WORD_W] == 0) ? 1 : int'(VEC[i][DIV_W+WORD_W-1:WORD_W]);
            send(VEC[i][WORD_W-1:0], VEC[i][DIV_W+WORD_W-1:WORD_W], cyc);
            check("R7 done in first idle cycle", 32'(done), 1);
            check("R5 busy length", 32'(cyc), 32'(48 * dexp));
            check("R1 word received", 32'(rx_latched), 32'(VEC[i][WORD_W-1:0]));
            check("R1 rise count", 32'(rx_rises - rise0), 12);
            check("R2 no early flag", 32'(rx_flag_err - err0), 0);
            check("R3 single latch", 32'(rx_latches - lat0), 1);
            @(negedge clk);
            check("R7 done one cycle", 32'(done), 0);
            check("R4 idle lines", 32'({sclk, sdata}), 0);
        end

        // R8 + R9: start and input changes mid-transfer
        lat0 = rx_latches;
        word_in = 12'h3C3; div_in = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        word_in = 12'h0F0; div_in = 8'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 11;
        while (busy) begin cyc++; @(negedge clk); end
        check("R9 length unchanged", 32'(cyc), 48);
        check("R9 word unchanged", 32'(rx_latched), 32'h3C3);
        check("R8 one latch", 32'(rx_latches - lat0), 1);
        repeat (60) @(negedge clk);
        check("R8 no extra transfer", 32'(busy), 0);
        check("R8 no extra latch", 32'(rx_latches - lat0), 1);

        // R10: start in the done cycle
        lat0 = rx_latches;
        send(12'h5A5, 8'd1, cyc);
        check("R10 done seen", 32'(done), 1);
        send(12'hC33, 8'd2, cyc);
        check("R10 first word", 32'(rx_latches - lat0), 2);
        check("R10 back-to-back length", 32'(cyc), 96);
        check("R10 second word", 32'(rx_latched), 32'hC33);

        // R6 spot check: sdata stable at a rise, via divider 3 probe
        word_in = 12'h800; div_in = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 data set before rise", 32'({sclk, sdata}), 32'b01);
        @(negedge clk);
        check("R6 rise keeps data", 32'({sclk, sdata}), 32'b11);
        while (busy) @(negedge clk);
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule